// File: doc/BRIEF.md
# Fixed-Cycle Countdown Timer Interrupt

This block counts a 16-bit preset down toward terminal count. It is paced by one of five prepared tick strobes: 4096 Hz, 64 Hz, 1 Hz, once per minute and once per hour. The shortest period is therefore one 4096 Hz tick, about 244 µs. The longest is 65535 hours. On every terminal count the block raises a sticky timer flag. If interrupts are enabled, it also pulls an active-low open-drain interrupt line low. The counter then reloads the preset on the same tick and starts the next period. The interrupt line lets go by itself a short time later, on the second 64 Hz release strobe after the event. The host does not have to act for this release.

A host programs the block through a byte-wide register port. The port holds the two preset bytes, a control byte and a status byte. It can also read back the live count. The control byte carries a run bit, an interrupt enable, a hold bit and a source code. The hold bit freezes the count. The count resumes from the frozen value once hold is cleared. Clearing run parks the counter on the preset. The tick strobes are generated outside this block.

Top module: `cycle_timer`

## Requirements
- R1: After reset, every register reads 0, the count reads 0, the flag is clear and the interrupt line is released (irq_drive_low = 0).
- R2: The register map is as follows. Address 0 holds preset bits 7:0 and address 1 holds preset bits 15:8. Address 2 is control, with run in bit 0, interrupt enable in bit 1, hold in bit 2 and the source code in bits 6:4. Address 3 is status, with the flag in bit 0. Addresses 4 and 5 return count bits 7:0 and 15:8. Control reads back as written, and unused bits read 0.
- R3: While run is 0, the count is loaded from the preset on every clock. Ticks have no effect and no event occurs.
- R4: Only the tick strobe picked by the source code decrements the count. Code 0 picks src_tick[0] (4096 Hz), 1 picks [1] (64 Hz), 2 picks [2] (1 Hz), 3 picks [3] (per minute) and 4 picks [4] (per hour). Codes 5 to 7 pick none.
- R5: Each selected tick lowers a count above 1 by one. A tick at count 1 produces an event and reloads the preset on that same tick. The block therefore gives one event every preset ticks, and repeats this while it runs.
- R6: While hold is 1, ticks leave the count unchanged. After hold is cleared, counting continues from the held value, not from the preset.
- R7: An event sets the flag, and the flag stays set until a write to address 3 with bit 0 = 0. A write with bit 0 = 1 has no effect. If an event and a clear fall on the same cycle, the event wins.
- R8: With interrupt enable at 1, an event drives the interrupt line low on the next clock. With interrupt enable at 0, the line stays released, while the flag is still set.
- R9: The interrupt line releases on the second release strobe after the latest event. An event that arrives while the line is low restarts this strobe count.
- R10: A preset of 0 never produces an event, and the count stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| src_tick | input | 5 | One-cycle tick strobes of the five source rates |
| rel_strobe | input | 1 | One-cycle 64 Hz strobe that times the interrupt release |
| irq_drive_low | output | 1 | 1 pulls the open-drain interrupt pin low, 0 leaves it at high impedance |

## Verification
The bench checks that a tick at count 1 both raises the event and reloads the preset in the same cycle. A design that reloaded one tick late would stretch every period by one tick, and a design that counted to 0 would do the same. After a pause, the bench expects the count to continue from the held value. A design that restarted from the preset at that point would show the preset in the count. The bench also fires a second event while the line is still low and counts the release strobes that follow. A design that kept its old strobe count would release the line one strobe early. Preset 0, the unused source codes and writing 1 to the flag bit must all leave the count, the flag and the line untouched.

// File: rtl/cyc_tmr_pkg.sv
// Shared constants and types for the fixed-cycle countdown timer.
// Assumes a byte-wide register port and a 16-bit preset split over two bytes.
package cyc_tmr_pkg;
    localparam int CNT_W   = 16;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int NUM_SRC = 5;
    localparam int SEL_W   = 3;

    localparam logic [ADDR_W-1:0] A_PRE_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_PRE_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd5;

    typedef struct packed {
        logic [SEL_W-1:0] src;
        logic             hold;
        logic             irq_en;
        logic             run;
    } ctrl_t;
endpackage

// File: rtl/cyc_tmr_regs.sv
// Register file of the countdown timer: preset bytes, control fields and the
// sticky event flag, plus the combinational read mux.
// Assumes one write per cycle; an event has priority over a flag clear.
module cyc_tmr_regs
    import cyc_tmr_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          event_i,
    input  logic [CW-1:0] count_i,
    output logic [CW-1:0] preset_o,
    output ctrl_t         ctrl_o,
    output logic          flag_o
);
    localparam int CTRL_W = $bits(ctrl_t);

    logic [CW-1:0] preset_q;
    ctrl_t         ctrl_q;
    logic          flag_q;
    logic          clr_req;

    // Decode a host write of 0 into the flag bit.
    assign clr_req = wr_en && (wr_addr == A_STAT) && !wr_data[0];

    // Preset and control storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preset_q <= '0;
            ctrl_q   <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_PRE_LO: preset_q[DW-1:0]  <= wr_data;
                A_PRE_HI: preset_q[CW-1:DW] <= wr_data[CW-DW-1:0];
                A_CTRL:   ctrl_q <= '{src:    wr_data[4 +: SEL_W],
                                     hold:   wr_data[2],
                                     irq_en: wr_data[1],
                                     run:    wr_data[0]};
                default:  ;
            endcase
        end
    end

    // Sticky event flag, set by events and cleared only by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (event_i) flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
    end

    // Read mux over the register map.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_PRE_LO: rd_data = preset_q[DW-1:0];
            A_PRE_HI: rd_data = preset_q[CW-1:DW];
            A_CTRL:   rd_data = {1'b0, ctrl_q.src, 1'b0,
                                 ctrl_q[CTRL_W-SEL_W-1:0]};
            A_STAT:   rd_data = {{(DW-1){1'b0}}, flag_q};
            A_CNT_LO: rd_data = count_i[DW-1:0];
            A_CNT_HI: rd_data = count_i[CW-1:DW];
            default:  rd_data = '0;
        endcase
    end

    assign preset_o = preset_q;
    assign ctrl_o   = ctrl_q;
    assign flag_o   = flag_q;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        event_i |=> flag_o);                                        // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_req) |=> flag_o);                           // R7
endmodule

// File: rtl/cyc_tmr_counter.sv
// Down counter of the timer: selects the source tick, decrements on it,
// reloads the preset at terminal count and flags the event.
// Assumes tick strobes are one clock wide; preset 0 halts at 0.
module cyc_tmr_counter
    import cyc_tmr_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int NS = NUM_SRC,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] src_tick,
    input  logic [SW-1:0] src_sel,
    input  logic          run,
    input  logic          hold,
    input  logic [CW-1:0] preset,
    output logic [CW-1:0] count,
    output logic          event_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q;
    logic          tick_sel;
    logic          step;

    // Source multiplexer; out-of-range codes select no tick.
    always_comb begin
        tick_sel = 1'b0;
        for (int i = 0; i < NS; i++) begin
            if (src_sel == SW'(i)) tick_sel = src_tick[i];
        end
    end

    assign step    = run && !hold && tick_sel;
    assign event_o = step && (cnt_q == ONE);

    // Countdown with reload on the terminal tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (!run)             cnt_q <= preset;
        else if (event_o)          cnt_q <= preset;
        else if (step && cnt_q != '0) cnt_q <= cnt_q - ONE;
    end

    assign count = cnt_q;

    AST_IDLE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> count == $past(preset));                           // R3
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |=> count == $past(preset));                        // R5
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hold) |=> count == $past(count));                   // R6
    AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !event_o);                                // R10
endmodule

// File: rtl/cyc_tmr_release.sv
// Interrupt line driver: pulls low at an enabled event and lets go after
// a fixed number of release strobes, restarting the count on a new event.
// Assumes rel_strobe is one clock wide.
module cyc_tmr_release #(
    parameter int NREL = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic irq_en,
    input  logic rel_strobe,
    output logic drive_low
);
    localparam int SC_W = $clog2(NREL + 1);
    localparam logic [SC_W-1:0] LAST = SC_W'(NREL - 1);

    logic            active_q;
    logic [SC_W-1:0] scnt_q;

    // Line state and release strobe count.
    always_ff @(posedge clk) begin
        if (!rst_n || !irq_en) begin
            active_q <= 1'b0;
            scnt_q   <= '0;
        end else if (event_i) begin
            active_q <= 1'b1;
            scnt_q   <= '0;
        end else if (active_q && rel_strobe) begin
            if (scnt_q == LAST) begin
                active_q <= 1'b0;
                scnt_q   <= '0;
            end else begin
                scnt_q <= scnt_q + 1'b1;
            end
        end
    end

    assign drive_low = active_q;

    AST_IRQ_AT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (event_i && irq_en) |=> drive_low);                         // R8
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !drive_low);                                    // R8
    AST_HELD_TO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_low && irq_en && !rel_strobe) |=> drive_low);        // R9
endmodule

// File: rtl/cycle_timer.sv
// Top of the fixed-cycle countdown timer: joins register file, counter and
// interrupt release. Assumes prepared tick strobes and a 64 Hz release strobe.
module cycle_timer
    import cyc_tmr_pkg::*;
#(
    parameter int NREL = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [NUM_SRC-1:0]  src_tick,
    input  logic                rel_strobe,
    output logic                irq_drive_low
);
    logic [CNT_W-1:0] preset;
    logic [CNT_W-1:0] count;
    ctrl_t            ctrl;
    logic             tmr_event;
    logic             flag;

    cyc_tmr_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .event_i  (tmr_event),
        .count_i  (count),
        .preset_o (preset),
        .ctrl_o   (ctrl),
        .flag_o   (flag)
    );

    cyc_tmr_counter u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .src_sel  (ctrl.src),
        .run      (ctrl.run),
        .hold     (ctrl.hold),
        .preset   (preset),
        .count    (count),
        .event_o  (tmr_event)
    );

    cyc_tmr_release #(.NREL(NREL)) u_release (
        .clk        (clk),
        .rst_n      (rst_n),
        .event_i    (tmr_event),
        .irq_en     (ctrl.irq_en),
        .rel_strobe (rel_strobe),
        .drive_low  (irq_drive_low)
    );

    AST_EVENT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_event |=> flag);                                        // R7
endmodule

// File: tb/cycle_timer_bench.sv
`timescale 1ns/1ps
module cycle_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [4:0] src_tick = '0;
    logic       rel_strobe = 1'b0;
    logic       irq_drive_low;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string      req;
        bit         is_irq;
        logic [2:0] addr;
        logic [7:0] exp;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    cycle_timer u_cycle_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .src_tick(src_tick), .rel_strobe(rel_strobe),
        .irq_drive_low(irq_drive_low)
    );

    // Monitor: pops expected items and compares mid-cycle.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = sb_q.pop_front();
            act = it.is_irq ? {7'b0, irq_drive_low} : rd_data;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s %s addr %0d actual %0h expected %0h",
                         it.req, it.is_irq ? "irq" : "reg", it.addr, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic tick(input int s);
        src_tick[s] = 1'b1;
        step();
        src_tick = '0;
    endtask

    task automatic strobe();
        rel_strobe = 1'b1;
        step();
        rel_strobe = 1'b0;
    endtask

    // Driver side: push one expectation, let the monitor consume it.
    task automatic expect_reg(input string req, input logic [2:0] a,
                              input logic [7:0] e);
        item_t it;
        rd_addr = a;
        it = '{req: req, is_irq: 1'b0, addr: a, exp: e};
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic expect_irq(input string req, input bit e);
        item_t it;
        it = '{req: req, is_irq: 1'b1, addr: 3'd0, exp: {7'b0, e}};
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset state
        expect_reg("R1", 3'd2, 8'h00);
        expect_reg("R1", 3'd3, 8'h00);
        expect_reg("R1", 3'd4, 8'h00);
        expect_irq("R1", 1'b0);

        // R2 / R3: preset loads while idle; ticks ignored
        wr(3'd0, 8'h03); wr(3'd1, 8'h00);
        tick(2); step();
        expect_reg("R3", 3'd4, 8'h03);
        expect_reg("R2", 3'd0, 8'h03);
        wr(3'd2, 8'h23);                  // 1 Hz, irq_en, run
        expect_reg("R2", 3'd2, 8'h23);

        // R4: wrong source has no effect
        tick(0); tick(1); tick(3); tick(4);
        expect_reg("R4", 3'd4, 8'h03);
        // R5: countdown and reload on terminal tick
        tick(2);
        expect_reg("R5", 3'd4, 8'h02);
        tick(2);
        expect_reg("R5", 3'd4, 8'h01);
        expect_reg("R7", 3'd3, 8'h00);
        tick(2);
        expect_reg("R5", 3'd4, 8'h03);
        expect_reg("R7", 3'd3, 8'h01);
        expect_irq("R8", 1'b1);

        // R9: release on the second strobe
        strobe();
        expect_irq("R9", 1'b1);
        strobe();
        expect_irq("R9", 1'b0);
        expect_reg("R7", 3'd3, 8'h01);

        // R7: write 1 ignored, write 0 clears
        wr(3'd3, 8'h01);
        expect_reg("R7", 3'd3, 8'h01);
        wr(3'd3, 8'h00);
        expect_reg("R7", 3'd3, 8'h00);

        // R6: hold freezes and resumes from held value
        tick(2);
        expect_reg("R6", 3'd4, 8'h02);
        wr(3'd2, 8'h27);
        tick(2); tick(2); tick(2);
        expect_reg("R6", 3'd4, 8'h02);
        expect_reg("R6", 3'd3, 8'h00);
        wr(3'd2, 8'h23);
        tick(2);
        expect_reg("R6", 3'd4, 8'h01);

        // R3: stopping run reloads preset, ticks ignored
        wr(3'd2, 8'h22); step();
        expect_reg("R3", 3'd4, 8'h03);
        tick(2); tick(2); tick(2);
        expect_reg("R3", 3'd3, 8'h00);
        expect_reg("R3", 3'd4, 8'h03);

        // R4: unused source code 5 selects nothing
        wr(3'd2, 8'h53);
        for (int i = 0; i < 5; i++) tick(i);
        expect_reg("R4", 3'd4, 8'h03);

        // R5 / R9: preset 1 on 4096 Hz, repeating events, release restart
        wr(3'd2, 8'h00);
        wr(3'd0, 8'h01); step();
        wr(3'd2, 8'h03);
        tick(0);
        expect_irq("R5", 1'b1);
        expect_reg("R5", 3'd4, 8'h01);
        strobe();
        tick(0);                          // new event restarts release
        expect_reg("R5", 3'd3, 8'h01);
        strobe();
        expect_irq("R9", 1'b1);
        strobe();
        expect_irq("R9", 1'b0);
        wr(3'd3, 8'h00);
        tick(0);
        expect_reg("R5", 3'd3, 8'h01);

        // R8: irq disabled, flag still set, line stays released
        wr(3'd2, 8'h01);
        wr(3'd3, 8'h00);
        tick(0);
        expect_reg("R8", 3'd3, 8'h01);
        expect_irq("R8", 1'b0);

        // R10: preset 0 gives no events
        wr(3'd2, 8'h00);
        wr(3'd0, 8'h00); wr(3'd3, 8'h00); step();
        wr(3'd2, 8'h03);
        tick(0); tick(0); tick(0);
        expect_reg("R10", 3'd3, 8'h00);
        expect_reg("R10", 3'd4, 8'h00);
        expect_irq("R10", 1'b0);

        // R4 / R2: hourly source with a 16-bit preset
        wr(3'd2, 8'h00);
        wr(3'd0, 8'h02); wr(3'd1, 8'h01); step();
        expect_reg("R2", 3'd5, 8'h01);
        wr(3'd2, 8'h43);
        tick(4);
        expect_reg("R4", 3'd4, 8'h01);
        expect_reg("R4", 3'd5, 8'h01);
        wr(3'd0, 8'h02); wr(3'd1, 8'h00);
        for (int i = 0; i < 256; i++) tick(4);
        expect_reg("R5", 3'd4, 8'h01);
        tick(4);
        expect_reg("R5", 3'd3, 8'h01);
        expect_reg("R5", 3'd4, 8'h02);
        expect_irq("R8", 1'b1);

        repeat (2) step();
        finish_run();
    end
endmodule